// File: doc/BRIEF.md
# Registered Tri-Port Bus Exchanger

This block moves data between a host-side port (A) and two memory-side ports (1B and 2B). Typically 1B serves the even bank and 2B serves the odd bank of an interleaved memory. Four independent storage registers hold the traffic, one for each direction of each path:

- A toward 1B
- A toward 2B
- 1B toward A
- 2B toward A

Each register has its own active-low load enable, sampled on the rising clock edge.

A path select chooses which of the two return registers appears on port A. It is captured on the clock edge, as are the two active-low drive controls. The first control governs port A. The second is shared by both B ports. Because these controls are registered, every change of direction happens exactly on a clock edge.

Each bidirectional port is split into an input bus, an output bus and an active-high drive flag, so no tri-state logic is needed. Every output is taken from flip-flops through at most a two-way mux. No path runs from an input data bus to an output data bus within one cycle.

Top module: `bus_exchanger`

## Requirements
- R1: An active-high synchronous reset clears all four data registers to zero. It sets the captured select to the 1B path (value 1). It clears both drive flags, so `a_drv`, `b_drv`, `a_out`, `b1_out` and `b2_out` all read 0.
- R2: The A-to-1B register takes `a_in` at a rising edge where `ld_a1b_n` is 0, and keeps its value otherwise. Its content is presented on `b1_out`.
- R3: The A-to-2B register takes `a_in` at a rising edge where `ld_a2b_n` is 0, and keeps its value otherwise. Its content is presented on `b2_out`. This register is independent of R2.
- R4: The 1B-to-A register takes `b1_in` at a rising edge where `ld_1ba_n` is 0, and keeps its value otherwise.
- R5: The 2B-to-A register takes `b2_in` at a rising edge where `ld_2ba_n` is 0, and keeps its value otherwise.
- R6: `path_1b` is captured at each rising edge. A captured 1 puts the 1B-to-A register on `a_out`, and a captured 0 puts the 2B-to-A register on `a_out`.
- R7: `a_drv` becomes 1 after an edge where `a_oe_n` was 0, and becomes 0 after an edge where `a_oe_n` was 1.
- R8: `b_drv` follows `b_oe_n`, registered and inverted as in R7. It controls both B ports together.
- R9: While a port's drive flag is 0, its output bus reads all zeros. The stored data is kept and reappears once the flag returns to 1.
- R10: When a register load and a select or enable change fall on the same edge, the output after that edge already shows the newly loaded data under the new select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Data arriving on port A |
| a_out | output | W | Data driven on port A |
| a_drv | output | 1 | Port A is driving |
| b1_in | input | W | Data arriving on port 1B |
| b1_out | output | W | Data driven on port 1B |
| b2_in | input | W | Data arriving on port 2B |
| b2_out | output | W | Data driven on port 2B |
| b_drv | output | 1 | Ports 1B and 2B are driving |
| ld_a1b_n | input | 1 | Load enable for the A-to-1B register, active low |
| ld_a2b_n | input | 1 | Load enable for the A-to-2B register, active low |
| ld_1ba_n | input | 1 | Load enable for the 1B-to-A register, active low |
| ld_2ba_n | input | 1 | Load enable for the 2B-to-A register, active low |
| path_1b | input | 1 | Return path select: 1 = 1B, 0 = 2B |
| a_oe_n | input | 1 | Port A drive request, active low |
| b_oe_n | input | 1 | Shared B-port drive request, active low |

## Verification
The delicate overlap is a return register being loaded on the same edge that the captured select switches to it, or that port A's drive is turned on. Port A must then show the fresh data at once, not the previous contents or the other bank. Directed steps provoke exactly this by changing load enable, select and drive request together. The random phase also produces it often, because all eight controls are drawn independently each cycle. Every output is compared after each edge against a bench model that is updated only from the values driven before that edge.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  typedef enum logic {
    PATH_2B = 1'b0,
    PATH_1B = 1'b1
  } path_e;
endpackage

// File: rtl/xchg_store.sv
module xchg_store #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic load_evt;
  assign load_evt = ~ld_n;

  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (load_evt) q <= d;
  end

  AST_STORE_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> (q == $past(d)));   // R2, R3, R4, R5
  AST_STORE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> $stable(q));       // R2, R3, R4, R5
endmodule

// File: rtl/xchg_ctrl.sv
module xchg_ctrl
  import xchg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  path_1b,
  input  logic  a_oe_n,
  input  logic  b_oe_n,
  output path_e path_q,
  output logic  a_drv_q,
  output logic  b_drv_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      path_q  <= PATH_1B;
      a_drv_q <= 1'b0;
      b_drv_q <= 1'b0;
    end else begin
      path_q  <= path_1b ? PATH_1B : PATH_2B;
      a_drv_q <= ~a_oe_n;
      b_drv_q <= ~b_oe_n;
    end
  end
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
  import xchg_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  input  logic [W-1:0] b1_in,
  output logic [W-1:0] b1_out,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] b2_out,
  output logic         b_drv,
  input  logic         ld_a1b_n,
  input  logic         ld_a2b_n,
  input  logic         ld_1ba_n,
  input  logic         ld_2ba_n,
  input  logic         path_1b,
  input  logic         a_oe_n,
  input  logic         b_oe_n
);
  localparam logic [W-1:0] IDLE = '0;

  logic [W-1:0] r_a1b, r_a2b, r_1ba, r_2ba;
  logic [W-1:0] ret_sel;
  path_e        path_q;

  function automatic logic [W-1:0] pick_return(input path_e p,
                                               input logic [W-1:0] from1,
                                               input logic [W-1:0] from2);
    return (p == PATH_1B) ? from1 : from2;
  endfunction

  function automatic logic [W-1:0] gate_out(input logic drv,
                                            input logic [W-1:0] v);
    return drv ? v : IDLE;
  endfunction

  xchg_store #(.W(W)) u_a1b (.clk(clk), .rst(rst), .ld_n(ld_a1b_n), .d(a_in),  .q(r_a1b));
  xchg_store #(.W(W)) u_a2b (.clk(clk), .rst(rst), .ld_n(ld_a2b_n), .d(a_in),  .q(r_a2b));
  xchg_store #(.W(W)) u_1ba (.clk(clk), .rst(rst), .ld_n(ld_1ba_n), .d(b1_in), .q(r_1ba));
  xchg_store #(.W(W)) u_2ba (.clk(clk), .rst(rst), .ld_n(ld_2ba_n), .d(b2_in), .q(r_2ba));

  xchg_ctrl u_ctrl (
    .clk(clk), .rst(rst), .path_1b(path_1b), .a_oe_n(a_oe_n), .b_oe_n(b_oe_n),
    .path_q(path_q), .a_drv_q(a_drv), .b_drv_q(b_drv)
  );

  assign ret_sel = pick_return(path_q, r_1ba, r_2ba);
  assign a_out   = gate_out(a_drv, ret_sel);
  assign b1_out  = gate_out(b_drv, r_a1b);
  assign b2_out  = gate_out(b_drv, r_a2b);

  AST_A_DRV_EDGE: assert property (@(posedge clk) disable iff (rst)
    !a_oe_n |=> a_drv);                                          // R7
  AST_A_OFF_EDGE: assert property (@(posedge clk) disable iff (rst)
    a_oe_n |=> !a_drv);                                          // R7
  AST_B_DRV_EDGE: assert property (@(posedge clk) disable iff (rst)
    !b_oe_n |=> b_drv);                                          // R8
  AST_A_QUIET: assert property (@(posedge clk) disable iff (rst)
    !a_drv |-> (a_out == '0));                                   // R9
  AST_PATH_1B: assert property (@(posedge clk) disable iff (rst)
    (path_1b && !ld_1ba_n && !a_oe_n) |=> (a_out == $past(b1_in))); // R6
  AST_PATH_2B: assert property (@(posedge clk) disable iff (rst)
    (!path_1b && !ld_2ba_n && !a_oe_n) |=> (a_out == $past(b2_in))); // R10
endmodule

// File: tb/sim_bus_exchanger.sv
module sim_bus_exchanger;
  localparam int W = 12;
  localparam time PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] a_in, b1_in, b2_in;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic a_drv, b_drv;
  logic ld_a1b_n, ld_a2b_n, ld_1ba_n, ld_2ba_n, path_1b, a_oe_n, b_oe_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [W-1:0] m_a1b, m_a2b, m_1ba, m_2ba;
  logic m_path, m_adrv, m_bdrv;

  always #(PERIOD/2) clk = ~clk;

  bus_exchanger #(.W(W)) u0 (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b1_in(b1_in), .b1_out(b1_out), .b2_in(b2_in), .b2_out(b2_out), .b_drv(b_drv),
    .ld_a1b_n(ld_a1b_n), .ld_a2b_n(ld_a2b_n), .ld_1ba_n(ld_1ba_n), .ld_2ba_n(ld_2ba_n),
    .path_1b(path_1b), .a_oe_n(a_oe_n), .b_oe_n(b_oe_n)
  );

  function automatic logic [W-1:0] exp_a();
    if (!m_adrv) return '0;
    return m_path ? m_1ba : m_2ba;
  endfunction

  function automatic logic [W-1:0] exp_b(input logic [W-1:0] r);
    return m_bdrv ? r : '0;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    check({"R6 a_out ", tag}, a_out, exp_a());
    check({"R2 b1_out ", tag}, b1_out, exp_b(m_a1b));
    check({"R3 b2_out ", tag}, b2_out, exp_b(m_a2b));
    check({"R7 a_drv ", tag}, W'(a_drv), W'(m_adrv));
    check({"R8 b_drv ", tag}, W'(b_drv), W'(m_bdrv));
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    if (rst) begin
      m_a1b = '0; m_a2b = '0; m_1ba = '0; m_2ba = '0;
      m_path = 1'b1; m_adrv = 1'b0; m_bdrv = 1'b0;
    end else begin
      if (!ld_a1b_n) m_a1b = a_in;
      if (!ld_a2b_n) m_a2b = a_in;
      if (!ld_1ba_n) m_1ba = b1_in;
      if (!ld_2ba_n) m_2ba = b2_in;
      m_path = path_1b;
      m_adrv = ~a_oe_n;
      m_bdrv = ~b_oe_n;
    end
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle_inputs();
    ld_a1b_n = 1; ld_a2b_n = 1; ld_1ba_n = 1; ld_2ba_n = 1;
    path_1b = 1; a_oe_n = 1; b_oe_n = 1;
  endtask

  initial begin
    #(PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1; a_in = 12'hFFF; b1_in = 12'hFFF; b2_in = 12'hFFF;
    ld_a1b_n = 0; ld_a2b_n = 0; ld_1ba_n = 0; ld_2ba_n = 0;
    path_1b = 0; a_oe_n = 0; b_oe_n = 0;
    @(negedge clk);
    step("R1 reset");
    step("R1 reset");
    check("R1 a_out zero", a_out, '0);
    check("R1 a_drv low", W'(a_drv), '0);
    rst = 0;
    idle_inputs();

    // R2, R3: load B-bound registers with B drive off, then enable (R9 keep)
    a_in = 12'h5A1; ld_a1b_n = 0; step("R2 load");
    check("R9 b1 quiet", b1_out, '0);
    ld_a1b_n = 1; a_in = 12'h0C3; ld_a2b_n = 0; step("R3 load");
    ld_a2b_n = 1; b_oe_n = 0; a_in = 12'hFFF; step("R9 reappear");
    check("R2 b1 kept", b1_out, 12'h5A1);
    check("R3 b2 kept", b2_out, 12'h0C3);

    // R4: load 1B return, select 1B, drive A same edge (R10)
    b1_in = 12'h111; b2_in = 12'h222; ld_1ba_n = 0; path_1b = 1; a_oe_n = 0;
    step("R4 R10 same edge");
    check("R4 a_out 1B", a_out, 12'h111);
    // R5: load 2B return and switch select same edge
    ld_1ba_n = 1; ld_2ba_n = 0; b2_in = 12'h2B2; path_1b = 0;
    step("R5 R10 switch");
    check("R5 a_out 2B", a_out, 12'h2B2);
    // R9: A drive off keeps data
    ld_2ba_n = 1; a_oe_n = 1; step("R9 off");
    check("R9 a quiet", a_out, '0);
    a_oe_n = 0; path_1b = 1; step("R6 back 1B");
    check("R6 a_out 1B kept", a_out, 12'h111);

    for (int i = 0; i < 2000; i++) begin
      a_in = W'($urandom); b1_in = W'($urandom); b2_in = W'($urandom);
      ld_a1b_n = 1'($urandom); ld_a2b_n = 1'($urandom);
      ld_1ba_n = 1'($urandom); ld_2ba_n = 1'($urandom);
      path_1b = 1'($urandom); a_oe_n = 1'($urandom); b_oe_n = 1'($urandom);
      rst = ($urandom % 200) == 0;
      step(rst ? "R1 random" : "R10 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule